// File: doc/BRIEF.md
# Multicycle Control Sequencer

This block is the control unit of a small multicycle processor. The processor has one memory and a datapath built around a shared address bus and a shared data bus. The controller reads the instruction word held in the datapath's instruction register, along with two status lines from the datapath: one shows that the two source registers are equal, and one shows that the first source register is negative. From these it drives a set of named control points. These control points select which source drives each bus, which registers load, whether the adder subtracts, whether the immediate replaces the second operand, and how the next PC is formed.

Operation alternates between two phases. In the fetch phase the PC addresses memory and the instruction register captures the word that memory returns. In the execute phase the controller raises the control points that the decoded instruction needs, and it always loads the PC. The register file, the adder, the memory array and the PC and instruction registers sit outside this block. They respond only to the control points it drives.

Top module: `mcs_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the block in the fetch phase (`in_exec` = 0). Out of reset the phase alternates on every clock: fetch, execute, fetch, and so on.
- R2: In fetch, only these outputs are high: `pc_on_abus`, `mem_on_dbus` and `ir_load`. `mem_write`, `reg_write` and `pc_load` are low, and `npc_src` is 0.
- R3: In execute, an opcode of 0 (bits 31:26) with function 0x21 (bits 5:0) raises `sum_on_dbus`, `reg_write` and `pc_load`. `imm_sel`, `sub_mode`, `mem_write` and `dest_is_rt` are low.
- R4: In execute, an opcode of 0 with function 0x23 drives the same outputs as R3, except that `sub_mode` is high.
- R5: In execute, opcode 0x23 raises `imm_sel`, `sum_on_abus`, `mem_on_dbus`, `reg_write`, `dest_is_rt` and `pc_load`. `sub_mode`, `pc_on_abus` and `mem_write` are low.
- R6: In execute, opcode 0x2B raises `regb_on_dbus`, `imm_sel`, `sum_on_abus`, `mem_write` and `pc_load`. `sub_mode`, `sum_on_dbus`, `mem_on_dbus`, `reg_write` and `pc_on_abus` are low.
- R7: In execute, opcode 0x04 sets `npc_src` to 1 (branch target) when `rs_eq_rt` is high and to 0 (PC+4) when it is low. No write strobe is raised.
- R8: In execute, opcode 0x01 with bits 20:16 equal to 0 sets `npc_src` to 1 when `rs_neg` is high and to 0 otherwise. Opcode 0x01 with any other value in bits 20:16 is unrecognised.
- R9: In execute, opcode 0x02 sets `npc_src` to 2 (jump field). An opcode of 0 with function 0x08 sets `npc_src` to 3 (register value). Neither raises a write strobe.
- R10: `pc_load` is high in every execute cycle and low in every fetch cycle.
- R11: An unrecognised word in execute raises only `pc_load`, with `npc_src` = 0. All bus sources and all write strobes are low.
- R12: In any cycle, at most one of `pc_on_abus` and `sum_on_abus` is high, and at most one of `sum_on_dbus`, `mem_on_dbus` and `regb_on_dbus` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | INSTR_W | Instruction register contents |
| rs_eq_rt | input | 1 | Datapath status: the two source registers are equal |
| rs_neg | input | 1 | Datapath status: the first source register is negative |
| in_exec | output | 1 | High in the execute phase, low in fetch |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | PC load |
| pc_on_abus | output | 1 | PC drives the address bus |
| sum_on_abus | output | 1 | Adder output drives the address bus |
| sum_on_dbus | output | 1 | Adder output drives the data bus |
| mem_on_dbus | output | 1 | Memory read data drives the data bus |
| regb_on_dbus | output | 1 | Second register operand drives the data bus |
| mem_write | output | 1 | Memory write strobe |
| reg_write | output | 1 | Register file write strobe |
| dest_is_rt | output | 1 | Destination register comes from bits 20:16 instead of 15:11 |
| imm_sel | output | 1 | Sign-extended immediate replaces the second adder operand |
| sub_mode | output | 1 | Adder inverts its second operand and sets carry-in |
| npc_src | output | 2 | Next PC: 0 PC+4, 1 branch target, 2 jump field, 3 register |

## Verification
The assertions check four things on every cycle: the phase alternates and returns to fetch after reset, no bus ever has two sources at once, fetch cycles never write, and a branch on equality follows the status line. The per-instruction sets of control points can only be shown by the bench. This covers the split between add and subtract, the store path driving the data bus from the register operand, and the case where the branch-if-negative opcode carries a nonzero second-register field and is treated as unrecognised. The bench also shows that a reset taken in the middle of an execute cycle sends the next cycle back to fetch.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

   localparam int OPC_W = 6;
   localparam int FN_W  = 6;
   localparam int REG_W = 5;

   localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
   localparam logic [OPC_W-1:0] OPC_REGIMM  = 6'h01;
   localparam logic [OPC_W-1:0] OPC_JUMP    = 6'h02;
   localparam logic [OPC_W-1:0] OPC_BEQ     = 6'h04;
   localparam logic [OPC_W-1:0] OPC_LOAD    = 6'h23;
   localparam logic [OPC_W-1:0] OPC_STORE   = 6'h2B;

   localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
   localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
   localparam logic [FN_W-1:0] FN_JR   = 6'h08;

   typedef enum logic [3:0] {
      IC_NONE, IC_ADDU, IC_SUBU, IC_LW, IC_SW, IC_J, IC_JR, IC_BEQ, IC_BLTZ
   } iclass_t;

   typedef enum logic [1:0] {
      NPC_SEQ    = 2'd0,
      NPC_BRANCH = 2'd1,
      NPC_JUMP   = 2'd2,
      NPC_REG    = 2'd3
   } npc_t;

   typedef struct packed {
      logic ir_load;
      logic pc_load;
      logic pc_on_abus;
      logic sum_on_abus;
      logic sum_on_dbus;
      logic mem_on_dbus;
      logic regb_on_dbus;
      logic mem_write;
      logic reg_write;
      logic dest_is_rt;
      logic imm_sel;
      logic sub_mode;
      npc_t npc_src;
   } ctl_t;

endpackage

// File: rtl/mcs_phase_reg.sv
module mcs_phase_reg #(
   parameter bit ONEHOT_STATE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   output logic in_exec
);

   generate
      if (ONEHOT_STATE) begin : g_onehot
         logic [1:0] st;   // bit0 fetch, bit1 execute
         always_ff @(posedge clk) begin
            if (rst) st <= 2'b01;
            else     st <= {st[0], st[1]};
         end
         assign in_exec = st[1];

         a_r1_state_onehot: assert property (@(posedge clk) disable iff (rst)
            $countones(st) == 1);
      end else begin : g_binary
         logic ph;
         always_ff @(posedge clk) begin
            if (rst) ph <= 1'b0;
            else     ph <= ~ph;
         end
         assign in_exec = ph;
      end
   endgenerate

   a_r1_reset_to_fetch: assert property (@(posedge clk) rst |=> !in_exec);
   a_r1_exec_then_fetch: assert property (@(posedge clk) disable iff (rst)
      in_exec |=> !in_exec);
   a_r1_fetch_then_exec: assert property (@(posedge clk) disable iff (rst)
      (!in_exec && !$past(rst)) |=> (in_exec || rst));

endmodule

// File: rtl/mcs_decode.sv
module mcs_decode
   import mcs_pkg::*;
#(
   parameter int INSTR_W = 32
) (
   input  logic [INSTR_W-1:0] instr,
   output iclass_t            cls
);

   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int RT_LSB  = OPC_LSB - 2*REG_W;

   generate
      if (INSTR_W != 32) begin : g_bad_width
         $error("mcs_decode: INSTR_W must be 32");
      end
   endgenerate

   logic [OPC_W-1:0] opc;
   logic [REG_W-1:0] rt_f;
   logic [FN_W-1:0]  fn;

   assign opc  = instr[INSTR_W-1 -: OPC_W];
   assign rt_f = instr[RT_LSB +: REG_W];
   assign fn   = instr[FN_W-1:0];

   always_comb begin
      cls = IC_NONE;
      unique case (opc)
         OPC_SPECIAL: begin
            case (fn)
               FN_ADDU: cls = IC_ADDU;
               FN_SUBU: cls = IC_SUBU;
               FN_JR:   cls = IC_JR;
               default: cls = IC_NONE;
            endcase
         end
         OPC_REGIMM: cls = (rt_f == '0) ? IC_BLTZ : IC_NONE;
         OPC_JUMP:   cls = IC_J;
         OPC_BEQ:    cls = IC_BEQ;
         OPC_LOAD:   cls = IC_LW;
         OPC_STORE:  cls = IC_SW;
         default:    cls = IC_NONE;
      endcase
   end

endmodule

// File: rtl/mcs_ctrl_gen.sv
module mcs_ctrl_gen
   import mcs_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    in_exec,
   input  iclass_t cls,
   input  logic    rs_eq_rt,
   input  logic    rs_neg,
   output ctl_t    ctl
);

   always_comb begin
      ctl = '0;
      ctl.npc_src = NPC_SEQ;
      if (!in_exec) begin
         ctl.pc_on_abus  = 1'b1;
         ctl.mem_on_dbus = 1'b1;
         ctl.ir_load     = 1'b1;
      end else begin
         ctl.pc_load = 1'b1;
         case (cls)
            IC_ADDU, IC_SUBU: begin
               ctl.sum_on_dbus = 1'b1;
               ctl.reg_write   = 1'b1;
               ctl.sub_mode    = (cls == IC_SUBU);
            end
            IC_LW: begin
               ctl.imm_sel     = 1'b1;
               ctl.sum_on_abus = 1'b1;
               ctl.mem_on_dbus = 1'b1;
               ctl.reg_write   = 1'b1;
               ctl.dest_is_rt  = 1'b1;
            end
            IC_SW: begin
               ctl.regb_on_dbus = 1'b1;
               ctl.imm_sel      = 1'b1;
               ctl.sum_on_abus  = 1'b1;
               ctl.mem_write    = 1'b1;
            end
            IC_BEQ:  ctl.npc_src = rs_eq_rt ? NPC_BRANCH : NPC_SEQ;
            IC_BLTZ: ctl.npc_src = rs_neg   ? NPC_BRANCH : NPC_SEQ;
            IC_J:    ctl.npc_src = NPC_JUMP;
            IC_JR:   ctl.npc_src = NPC_REG;
            default: ctl.npc_src = NPC_SEQ;
         endcase
      end
   end

   a_r12_abus_single: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl.pc_on_abus, ctl.sum_on_abus}));
   a_r12_dbus_single: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl.sum_on_dbus, ctl.mem_on_dbus, ctl.regb_on_dbus}));
   a_r2_fetch_no_write: assert property (@(posedge clk) disable iff (rst)
      !in_exec |-> (!ctl.mem_write && !ctl.reg_write && !ctl.pc_load));
   a_r11_none_quiet: assert property (@(posedge clk) disable iff (rst)
      (in_exec && cls == IC_NONE) |-> (!ctl.mem_write && !ctl.reg_write
                                      && ctl.npc_src == NPC_SEQ));

endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
   import mcs_pkg::*;
#(
   parameter int INSTR_W      = 32,
   parameter bit ONEHOT_STATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr_word,
   input  logic               rs_eq_rt,
   input  logic               rs_neg,
   output logic               in_exec,
   output logic               ir_load,
   output logic               pc_load,
   output logic               pc_on_abus,
   output logic               sum_on_abus,
   output logic               sum_on_dbus,
   output logic               mem_on_dbus,
   output logic               regb_on_dbus,
   output logic               mem_write,
   output logic               reg_write,
   output logic               dest_is_rt,
   output logic               imm_sel,
   output logic               sub_mode,
   output logic [1:0]         npc_src
);

   iclass_t cls;
   ctl_t    ctl;

   mcs_phase_reg #(.ONEHOT_STATE(ONEHOT_STATE)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .in_exec (in_exec)
   );

   mcs_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr (instr_word),
      .cls   (cls)
   );

   mcs_ctrl_gen u_gen (
      .clk      (clk),
      .rst      (rst),
      .in_exec  (in_exec),
      .cls      (cls),
      .rs_eq_rt (rs_eq_rt),
      .rs_neg   (rs_neg),
      .ctl      (ctl)
   );

   assign ir_load      = ctl.ir_load;
   assign pc_load      = ctl.pc_load;
   assign pc_on_abus   = ctl.pc_on_abus;
   assign sum_on_abus  = ctl.sum_on_abus;
   assign sum_on_dbus  = ctl.sum_on_dbus;
   assign mem_on_dbus  = ctl.mem_on_dbus;
   assign regb_on_dbus = ctl.regb_on_dbus;
   assign mem_write    = ctl.mem_write;
   assign reg_write    = ctl.reg_write;
   assign dest_is_rt   = ctl.dest_is_rt;
   assign imm_sel      = ctl.imm_sel;
   assign sub_mode     = ctl.sub_mode;
   assign npc_src      = ctl.npc_src;

   a_r7_beq_taken: assert property (@(posedge clk) disable iff (rst)
      (in_exec && instr_word[INSTR_W-1 -: OPC_W] == OPC_BEQ && rs_eq_rt)
      |-> (npc_src == 2'd1));
   a_r7_beq_not_taken: assert property (@(posedge clk) disable iff (rst)
      (in_exec && instr_word[INSTR_W-1 -: OPC_W] == OPC_BEQ && !rs_eq_rt)
      |-> (npc_src == 2'd0 && !mem_write && !reg_write));
   a_r10_pc_load_exec: assert property (@(posedge clk) disable iff (rst)
      in_exec |-> pc_load);

endmodule

// File: tb/mcs_sequencer_tb_top.sv
`timescale 1ns/1ps
module mcs_sequencer_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr_word = '0;
   logic        rs_eq_rt = 1'b0;
   logic        rs_neg = 1'b0;
   logic        in_exec, ir_load, pc_load, pc_on_abus, sum_on_abus, sum_on_dbus;
   logic        mem_on_dbus, regb_on_dbus, mem_write, reg_write, dest_is_rt;
   logic        imm_sel, sub_mode;
   logic [1:0]  npc_src;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   logic        exp_exec = 1'b0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   mcs_sequencer dut_i (
      .clk(clk), .rst(rst), .instr_word(instr_word), .rs_eq_rt(rs_eq_rt),
      .rs_neg(rs_neg), .in_exec(in_exec), .ir_load(ir_load), .pc_load(pc_load),
      .pc_on_abus(pc_on_abus), .sum_on_abus(sum_on_abus),
      .sum_on_dbus(sum_on_dbus), .mem_on_dbus(mem_on_dbus),
      .regb_on_dbus(regb_on_dbus), .mem_write(mem_write),
      .reg_write(reg_write), .dest_is_rt(dest_is_rt), .imm_sel(imm_sel),
      .sub_mode(sub_mode), .npc_src(npc_src)
   );

   // order: ir_load pc_load pc_on_abus sum_on_abus sum_on_dbus mem_on_dbus
   //        regb_on_dbus mem_write reg_write dest_is_rt imm_sel sub_mode npc_src[1:0]
   function automatic logic [13:0] model(input logic ex, input logic [31:0] w,
                                         input logic eq, input logic ng,
                                         output string req);
      logic [5:0] op = w[31:26];
      logic [5:0] fn = w[5:0];
      logic [4:0] rt = w[20:16];
      if (!ex) begin
         req = "R2";
         return 14'b1_0_1_0_0_1_0_0_0_0_0_0_00;
      end
      if (op == 6'h00 && fn == 6'h21) begin req = "R3";
         return 14'b0_1_0_0_1_0_0_0_1_0_0_0_00; end
      if (op == 6'h00 && fn == 6'h23) begin req = "R4";
         return 14'b0_1_0_0_1_0_0_0_1_0_0_1_00; end
      if (op == 6'h23) begin req = "R5";
         return 14'b0_1_0_1_0_1_0_0_1_1_1_0_00; end
      if (op == 6'h2B) begin req = "R6";
         return 14'b0_1_0_1_0_0_1_1_0_0_1_0_00; end
      if (op == 6'h04) begin req = "R7";
         return {12'b0_1_0_0_0_0_0_0_0_0_0_0, 1'b0, eq}; end
      if (op == 6'h01 && rt == 5'd0) begin req = "R8";
         return {12'b0_1_0_0_0_0_0_0_0_0_0_0, 1'b0, ng}; end
      if (op == 6'h02) begin req = "R9";
         return 14'b0_1_0_0_0_0_0_0_0_0_0_0_10; end
      if (op == 6'h00 && fn == 6'h08) begin req = "R9";
         return 14'b0_1_0_0_0_0_0_0_0_0_0_0_11; end
      req = "R11";
      return 14'b0_1_0_0_0_0_0_0_0_0_0_0_00;
   endfunction

   task automatic check_now(input logic [31:0] w, input logic eq, input logic ng);
      string       req;
      logic [13:0] exp_v = model(exp_exec, w, eq, ng, req);
      logic [13:0] act_v = {ir_load, pc_load, pc_on_abus, sum_on_abus, sum_on_dbus,
                            mem_on_dbus, regb_on_dbus, mem_write, reg_write,
                            dest_is_rt, imm_sel, sub_mode, npc_src};
      n_cmp++;
      if (in_exec !== exp_exec) begin
         n_bad++;
         $display("FAIL R1 phase: got %b expected %b", in_exec, exp_exec);
      end
      n_cmp++;
      if (act_v !== exp_v) begin
         n_bad++;
         $display("FAIL %s word=%h: got %b expected %b", req, w, act_v, exp_v);
      end
      n_cmp++;   // R12 bus exclusivity
      if ($countones({pc_on_abus, sum_on_abus}) > 1 ||
          $countones({sum_on_dbus, mem_on_dbus, regb_on_dbus}) > 1) begin
         n_bad++;
         $display("FAIL R12 bus sources: got a=%b%b d=%b%b%b expected at most one each",
                  pc_on_abus, sum_on_abus, sum_on_dbus, mem_on_dbus, regb_on_dbus);
      end
      n_cmp++;   // R10 pc load tracks phase
      if (pc_load !== exp_exec) begin
         n_bad++;
         $display("FAIL R10 pc_load: got %b expected %b", pc_load, exp_exec);
      end
   endtask

   task automatic step(input logic [31:0] w, input logic eq, input logic ng,
                       input logic r);
      @(negedge clk);
      instr_word = w; rs_eq_rt = eq; rs_neg = ng;
      #1;
      check_now(w, eq, ng);
      rst = r;
      exp_exec = r ? 1'b0 : ~exp_exec;
   endtask

   function automatic logic [31:0] rand_word(input int unsigned kind);
      logic [31:0] w = $urandom;
      case (kind)
         0: w = {6'h00, w[25:6], 6'h21};
         1: w = {6'h00, w[25:6], 6'h23};
         2: w = {6'h23, w[25:0]};
         3: w = {6'h2B, w[25:0]};
         4: w = {6'h04, w[25:0]};
         5: w = {6'h01, w[25:21], 5'd0, w[15:0]};
         6: w = {6'h02, w[25:0]};
         7: w = {6'h00, w[25:6], 6'h08};
         default: ;
      endcase
      return w;
   endfunction

   initial begin
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(posedge clk);
      // R1: reset state is fetch; release reset here
      step(32'h0000_0021, 1'b0, 1'b0, 1'b0);
      // directed corners
      step(32'h0000_0021, 1'b0, 1'b0, 1'b0);   // R3 addu
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'h0000_0023, 1'b0, 1'b0, 1'b0);   // R4 subu
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'h8C00_0004, 1'b0, 1'b0, 1'b0);   // R5 lw
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'hAC00_0004, 1'b0, 1'b0, 1'b0);   // R6 sw
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'h1000_0003, 1'b1, 1'b0, 1'b0);   // R7 beq taken
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'h1000_0003, 1'b0, 1'b1, 1'b0);   // R7 beq not taken
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'h0400_0002, 1'b0, 1'b1, 1'b0);   // R8 bltz taken
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'h0401_0002, 1'b1, 1'b1, 1'b0);   // R8 rt!=0 -> unrecognised (R11)
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'h0800_1234, 1'b0, 1'b0, 1'b0);   // R9 j
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'h03E0_0008, 1'b0, 1'b0, 1'b0);   // R9 jr
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'h0000_0020, 1'b1, 1'b1, 1'b0);   // R11 unknown funct
      step(32'h0, 1'b0, 1'b0, 1'b0);
      step(32'hFC00_0000, 1'b1, 1'b1, 1'b1);   // R11 unknown op; R1 reset mid-execute
      step(32'h0000_0021, 1'b0, 1'b0, 1'b0);   // R1 back in fetch after reset
      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         step(rand_word($urandom % 10), 1'($urandom), 1'($urandom), 1'b0);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule